// File: doc/BRIEF.md
# ADC Result Register Interface

This block sits between a 10-bit converter core and a processor's register bus. Software writes a control register to start a conversion. A continuous bit in that write chooses between one conversion and an endless chain of conversions. Each finished result arrives from the core over a valid/ready transfer. The block formats the result into a high data byte and a low data byte, under one of four formats chosen by a two-bit format select. It keeps a sticky completion flag. It also runs a read-order lock: once the high byte has been read, no new result may overwrite the pair until the low byte has been read.

The core side works as a stream. `res_ready` is high only while a conversion is outstanding. A result transfers on a clock edge where `res_valid` and `res_ready` are both high. The core must hold `res_valid` and `res_data` until that edge. While the sequencer is idle, no result is accepted. A transfer made while the read lock is armed is consumed and counts as a completed conversion for sequencing, but its data is dropped. The register side uses plain strobes. `rd_data` is a combinational view of the byte that is addressed in the same cycle.

Top module: `adc_result_regs`

## Requirements
- R1: After reset both data bytes are 0, `done_flag` is 0 and `res_ready` is 0.
- R2: With format select 00 (left), a stored result d gives high byte = d[9:2] and low byte = {d[1:0], 6'b0}.
- R3: With format select 01 (right), a stored result d gives high byte = {6'b0, d[9:8]} and low byte = d[7:0].
- R4: With format select 10 (signed left), d[9] is inverted first, and the value is then placed as in R2.
- R5: With format select 11 (truncate), the high byte is 0 and the low byte is d[9:2]. A high-byte read in this format does not arm the read lock.
- R6: In formats 00, 01 and 10, a high-byte read arms the lock. Every result that transfers while the lock is armed is dropped: both bytes and `done_flag` are left unchanged. A low-byte read disarms the lock, effective from the next cycle.
- R7: `res_ready` rises in the cycle after a control write. With the continuous bit 0, it falls in the cycle after one result has transferred.
- R8: With the continuous bit 1, `res_ready` stays high across transfers, and each stored result overwrites both bytes whether or not they were read.
- R9: `done_flag` sets in the cycle after a stored result. It clears after a control write or a data-byte read. If a store and a clear happen in the same cycle, the store wins.
- R10: `rd_data` shows the high byte while `rd_hi` is high, the low byte while `rd_lo` is high, and 0 when neither is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Converter result valid |
| res_ready | output | 1 | A conversion is outstanding, so a result is accepted |
| res_data | input | 10 | Converter result, unsigned |
| fmt_sel | input | 2 | Result format select (00 left, 01 right, 10 signed left, 11 truncate) |
| ctl_wr | input | 1 | Control register write strobe; starts a conversion |
| ctl_cont | input | 1 | Continuous bit sampled with `ctl_wr` |
| rd_hi | input | 1 | High data byte read strobe |
| rd_lo | input | 1 | Low data byte read strobe |
| rd_data | output | 8 | Read data for the addressed byte |
| done_flag | output | 1 | Sticky conversion-complete flag |

## Verification
Some rules are checked by assertions on every cycle: a single conversion drops `res_ready` after its transfer, a control write raises it, a transfer under an armed lock leaves both bytes frozen, a store always raises `done_flag`, a clear with no store lowers it, and truncation leaves the high byte zero. Other behaviour only the bench scenarios can show. These are the exact byte images for every 10-bit value in all four formats, the order of reads that arms and disarms the lock, the lock being skipped in the truncate format, overwriting of unread data in continuous mode, and a store beating a read in the same cycle for the flag.

// File: rtl/adc_res_pkg.sv
package adc_res_pkg;
  typedef enum logic [1:0] {
    FMT_LEFT  = 2'b00,
    FMT_RIGHT = 2'b01,
    FMT_SLEFT = 2'b10,
    FMT_TRUNC = 2'b11
  } fmt_e;
endpackage

// File: rtl/adc_res_format.sv
module adc_res_format
  import adc_res_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic [RES_W-1:0]  res,
  input  logic [1:0]        fmt,
  output logic [BYTE_W-1:0] hi_fmt,
  output logic [BYTE_W-1:0] lo_fmt
);
  localparam int PAD = 2*BYTE_W - RES_W;
  localparam logic [RES_W-1:0] SIGN_MASK = {1'b1, {(RES_W-1){1'b0}}};

  logic [2*BYTE_W-1:0] word;
  logic [RES_W-1:0]    flipped;

  assign flipped = res ^ SIGN_MASK;

  always_comb begin
    word = '0;
    unique case (fmt_e'(fmt))
      FMT_LEFT:  word = {res, {PAD{1'b0}}};
      FMT_RIGHT: word = {{PAD{1'b0}}, res};
      FMT_SLEFT: word = {flipped, {PAD{1'b0}}};
      FMT_TRUNC: word = {{BYTE_W{1'b0}}, res[RES_W-1 -: BYTE_W]};
      default:   word = '0;
    endcase
  end

  assign hi_fmt = word[2*BYTE_W-1 -: BYTE_W];
  assign lo_fmt = word[BYTE_W-1:0];
endmodule

// File: rtl/adc_res_seq.sv
module adc_res_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic ctl_cont,
  input  logic res_valid,
  output logic busy
);
  logic busy_q, cont_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cont_q <= 1'b0;
    end else if (ctl_wr) begin
      busy_q <= 1'b1;
      cont_q <= ctl_cont;
    end else if (busy_q && res_valid && !cont_q) begin
      busy_q <= 1'b0;
    end
  end

  assign busy = busy_q;

  // R7
  single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && res_valid && !cont_q && !ctl_wr |=> !busy_q);
  // R7
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> busy_q);
endmodule

// File: rtl/adc_res_bank.sv
module adc_res_bank #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer,
  input  logic              trunc,
  input  logic [BYTE_W-1:0] hi_fmt,
  input  logic [BYTE_W-1:0] lo_fmt,
  input  logic              rd_hi,
  input  logic              rd_lo,
  input  logic              ctl_wr,
  output logic [BYTE_W-1:0] hi_q,
  output logic [BYTE_W-1:0] lo_q,
  output logic              flag
);
  logic lock_q, store, clr;

  assign store = xfer && !lock_q;
  assign clr   = ctl_wr || rd_hi || rd_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (store) begin
      hi_q <= hi_fmt;
      lo_q <= lo_fmt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                lock_q <= 1'b0;
    else if (rd_lo)            lock_q <= 1'b0;
    else if (rd_hi && !trunc)  lock_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (store)  flag <= 1'b1;
    else if (clr)    flag <= 1'b0;
  end

  // R6
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q && xfer |=> $stable(hi_q) && $stable(lo_q));
  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store |=> flag);
  // R9
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !store |=> !flag);
  // R5
  trunc_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store && trunc |=> hi_q == '0);
endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs
  import adc_res_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [RES_W-1:0]  res_data,
  input  logic [1:0]        fmt_sel,
  input  logic              ctl_wr,
  input  logic              ctl_cont,
  input  logic              rd_hi,
  input  logic              rd_lo,
  output logic [BYTE_W-1:0] rd_data,
  output logic              done_flag
);
  logic [BYTE_W-1:0] hi_fmt, lo_fmt, hi_q, lo_q;
  logic busy, xfer, trunc;

  assign xfer  = res_valid && busy;
  assign trunc = (fmt_e'(fmt_sel) == FMT_TRUNC);

  adc_res_seq u_seq (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_cont(ctl_cont),
    .res_valid(res_valid), .busy(busy)
  );

  adc_res_format #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_fmt (
    .res(res_data), .fmt(fmt_sel), .hi_fmt(hi_fmt), .lo_fmt(lo_fmt)
  );

  adc_res_bank #(.BYTE_W(BYTE_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .xfer(xfer), .trunc(trunc),
    .hi_fmt(hi_fmt), .lo_fmt(lo_fmt), .rd_hi(rd_hi), .rd_lo(rd_lo),
    .ctl_wr(ctl_wr), .hi_q(hi_q), .lo_q(lo_q), .flag(done_flag)
  );

  assign res_ready = busy;
  assign rd_data   = rd_hi ? hi_q : (rd_lo ? lo_q : '0);
endmodule

// File: tb/tb_adc_result_regs.sv
module tb_adc_result_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic res_valid = 0, ctl_wr = 0, ctl_cont = 0, rd_hi = 0, rd_lo = 0;
  logic res_ready, done_flag;
  logic [9:0] res_data = '0;
  logic [1:0] fmt_sel = '0;
  logic [7:0] rd_data;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  adc_result_regs dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .fmt_sel(fmt_sel), .ctl_wr(ctl_wr), .ctl_cont(ctl_cont),
    .rd_hi(rd_hi), .rd_lo(rd_lo), .rd_data(rd_data), .done_flag(done_flag)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic int exp_hi(int m, int d);
    int v = (m == 2) ? (d ^ 512) : d;
    case (m)
      0, 2: return v >> 2;
      1:    return v >> 8;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_lo(int m, int d);
    int v = (m == 2) ? (d ^ 512) : d;
    case (m)
      0, 2: return (v & 3) << 6;
      1:    return v & 255;
      default: return v >> 2;
    endcase
  endfunction

  task automatic start(bit cont);
    ctl_wr = 1; ctl_cont = cont; tick(); ctl_wr = 0; ctl_cont = 0;
  endtask

  task automatic feed(int d);
    res_valid = 1; res_data = 10'(d); tick(); res_valid = 0;
  endtask

  task automatic read_hi(string req, int exp);
    rd_hi = 1; #1 check(req, int'(rd_data), exp); tick(); rd_hi = 0;
  endtask

  task automatic read_lo(string req, int exp);
    rd_lo = 1; #1 check(req, int'(rd_data), exp); tick(); rd_lo = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check("R1 ready", int'(res_ready), 0);
    check("R1 flag", int'(done_flag), 0);
    rst_n = 1; tick();
    read_hi("R1 hi", 0);
    read_lo("R1 lo", 0);
    // R10 idle read data
    #1 check("R10 idle", int'(rd_data), 0);

    // R2 R3 R4 R5 sweep of all values and formats
    for (int m = 0; m < 4; m++) begin
      fmt_sel = 2'(m);
      for (int d = 0; d < 1024; d++) begin
        start(0);
        check("R7 ready rise", int'(res_ready), 1);
        feed(d);
        check("R7 ready fall", int'(res_ready), 0);
        check("R9 flag set", int'(done_flag), 1);
        case (m)
          0: begin read_hi("R2 hi", exp_hi(m, d)); read_lo("R2 lo", exp_lo(m, d)); end
          1: begin read_hi("R3 hi", exp_hi(m, d)); read_lo("R3 lo", exp_lo(m, d)); end
          2: begin read_hi("R4 hi", exp_hi(m, d)); read_lo("R4 lo", exp_lo(m, d)); end
          default: begin read_hi("R5 hi", 0); read_lo("R5 lo", exp_lo(m, d)); end
        endcase
        check("R9 flag clear", int'(done_flag), 0);
      end
    end

    // R6 lock drops a result after a high read
    fmt_sel = 2'b00;
    start(0); feed(10'h2D5);
    read_hi("R6 hi", exp_hi(0, 'h2D5));
    start(0); feed(10'h12A);
    check("R6 flag kept", int'(done_flag), 0);
    read_lo("R6 old lo", exp_lo(0, 'h2D5));
    start(0); feed(10'h12A);
    check("R6 stored after lo", int'(done_flag), 1);
    read_hi("R6 new hi", exp_hi(0, 'h12A));
    read_lo("R6 new lo", exp_lo(0, 'h12A));

    // R5 truncate: high read does not arm the lock
    fmt_sel = 2'b11;
    start(0); feed(10'h3F0);
    read_hi("R5 hi no lock", 0);
    start(0); feed(10'h0C4);
    read_lo("R5 no lock", exp_lo(3, 'h0C4));

    // R8 continuous overwrite
    fmt_sel = 2'b01;
    start(1);
    for (int k = 0; k < 3; k++) begin
      feed(100 + k * 200);
      check("R8 ready held", int'(res_ready), 1);
    end
    check("R8 flag", int'(done_flag), 1);
    read_lo("R8 lo last", exp_lo(1, 500));
    // R9 store wins over a same-cycle read
    res_valid = 1; res_data = 10'd777; rd_lo = 1; tick();
    res_valid = 0; rd_lo = 0;
    check("R9 store wins", int'(done_flag), 1);
    read_hi("R8 hi", exp_hi(1, 777));
    read_lo("R8 lo", exp_lo(1, 777));
    // stop continuous: write with bit clear runs one more conversion
    start(0);
    check("R9 write clears", int'(done_flag), 0);
    feed(33);
    check("R7 stop", int'(res_ready), 0);
    read_lo("R8 final lo", 33);

    finished = 1;
    summary();
  end
endmodule